// File: doc/BRIEF.md
# ADC Emulation Stimulus and Spy Buffers

This block holds three on-chip buffers for exercising an eight-channel processing chain without real converters. The stimulus buffer stores 96-bit words, each made of eight 12-bit channel samples, and replays them as if they came from a bank of ADCs. The trigger buffer stores 8-bit words with one pulse-trigger bit per channel and replays them in the same way. The capture buffer records 96-bit processing results so that they can be compared with expected values.

A host loads and reads every buffer over a byte-wide bus with an address, a write strobe and a read strobe. A setup register picks, for each buffer, whether its sample-side port is moved by host accesses or by the sample-enable strobe. For the stimulus and trigger buffers that port is the read side. For the capture buffer it is the write side. The whole block runs on one clock. The host strobes and the sample-enable strobe are single-cycle qualifiers on that clock.

Top module: `adcemu_top`

## Requirements
- R1: After reset all three buffers are empty, the setup register reads 0 (all buffers in host mode), the status register at address 0x11 reads 0x15, and both replay valid outputs are low.
- R2: Wide words (stimulus at 0x1F, capture at 0x1C) move as twelve byte transfers, least significant byte first. The trigger buffer at 0x06 moves one byte per word. A word enters a buffer only on its last byte. Host reads return words in the order they were written.
- R3: The byte position restarts at the first byte whenever the accessed address changes or the access direction changes between read and write. A partly transferred word is then discarded.
- R4: The setup register at 0x10 is read and written by the host. Bit 0 selects the stimulus buffer, bit 1 the trigger buffer and bit 2 the capture buffer. A 1 hands that buffer's sample-side port to the sample-enable strobe.
- R5: With its setup bit set, the stimulus or trigger buffer outputs the word at its current read address one cycle after each sample-enable pulse, with valid high for that cycle only. The address then advances and wraps from the last location to 0. The stored word count does not change.
- R6: With bit 2 set, each sample-enable pulse stores the capture input word while the capture buffer is not full. Once it is full, further samples are dropped. Host writes to the capture buffer are ignored in this mode.
- R7: The status register at 0x11 reports the flags in bits 0..5 in this order: stimulus empty, stimulus full, trigger empty, trigger full, capture empty, capture full. Full means 512 words are stored.
- R8: A host word written to a full buffer is dropped. A host read of an empty buffer returns 0 and consumes nothing.
- R9: While the stimulus or trigger buffer is in sample mode, host reads of it return 0 and consume nothing.
- R10: Host read data is registered and is valid in the cycle after the read strobe. It holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for the host port and the sample side |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 8 | Host port address |
| host_wr | input | 1 | Host byte write strobe |
| host_rd | input | 1 | Host byte read strobe |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Registered host read byte |
| samp_en | input | 1 | Sample-clock qualifier, one pulse per sample |
| stim_word | output | 96 | Replayed stimulus word (eight 12-bit samples) |
| stim_valid | output | 1 | Stimulus word valid |
| trig_word | output | 8 | Replayed trigger word, one bit per channel |
| trig_valid | output | 1 | Trigger word valid |
| cap_din | input | 96 | Processing result captured on sample pulses |

## Verification
The assertions assume that the host never raises its read and write strobes in the same cycle, and that a host changes the address only between complete word transfers when it wants a word kept. The bench drives each strobe for exactly one cycle from tasks. It mixes words drawn from a fixed-seed random source with deliberately truncated transfers and direction switches. Sample-enable pulses are only issued after the setup register has been written, so every replayed or captured word is compared against a bench-side model of the same contents.

// File: rtl/adcemu_pkg.sv
package adcemu_pkg;
   localparam int HOST_W = 8;
   localparam int IDX_W  = 4;

   localparam logic [7:0] ADDR_CAP    = 8'h1C;
   localparam logic [7:0] ADDR_STIM   = 8'h1F;
   localparam logic [7:0] ADDR_TRIG   = 8'h06;
   localparam logic [7:0] ADDR_SETUP  = 8'h10;
   localparam logic [7:0] ADDR_STATUS = 8'h11;

   localparam int SEL_STIM = 0;
   localparam int SEL_TRIG = 1;
   localparam int SEL_CAP  = 2;

   // status layout, bit 0 is the last member
   typedef struct packed {
      logic cap_full;
      logic cap_empty;
      logic trig_full;
      logic trig_empty;
      logic stim_full;
      logic stim_empty;
   } status_t;

   function automatic int bytes_per_word(input int width);
      return (width + HOST_W - 1) / HOST_W;
   endfunction
endpackage

// File: rtl/adcemu_host_seq.sv
module adcemu_host_seq
   import adcemu_pkg::*;
#(
   parameter int         STIM_NB   = 12,
   parameter int         TRIG_NB   = 1,
   parameter int         CAP_NB    = 12,
   parameter logic [7:0] STIM_ADDR = ADDR_STIM,
   parameter logic [7:0] TRIG_ADDR = ADDR_TRIG,
   parameter logic [7:0] CAP_ADDR  = ADDR_CAP
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [7:0]       addr,
   input  logic             wr,
   input  logic             rd,
   output logic [IDX_W-1:0] idx
);
   localparam int MAX_NB = (STIM_NB > CAP_NB) ? ((STIM_NB > TRIG_NB) ? STIM_NB : TRIG_NB)
                                              : ((CAP_NB > TRIG_NB) ? CAP_NB : TRIG_NB);

   generate
      if (MAX_NB > (1 << IDX_W)) begin : g_bad_idx
         $error("byte index too narrow for the widest word");
      end
      if (STIM_NB < 1 || TRIG_NB < 1 || CAP_NB < 1) begin : g_bad_nb
         $error("each word needs at least one byte");
      end
   endgenerate

   logic [IDX_W-1:0] cnt_q;
   logic [IDX_W-1:0] last_idx;
   logic [7:0]       prev_addr_q;
   logic             prev_rd_q;
   logic             prev_ok_q;
   logic             access;
   logic             same_stream;

   assign access = wr | rd;

   always_comb begin
      case (addr)
         STIM_ADDR: last_idx = IDX_W'(STIM_NB - 1);
         TRIG_ADDR: last_idx = IDX_W'(TRIG_NB - 1);
         CAP_ADDR:  last_idx = IDX_W'(CAP_NB - 1);
         default:   last_idx = '0;
      endcase
   end

   assign same_stream = prev_ok_q && (addr == prev_addr_q) && (rd == prev_rd_q);
   assign idx         = same_stream ? cnt_q : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q       <= '0;
         prev_addr_q <= '0;
         prev_rd_q   <= 1'b0;
         prev_ok_q   <= 1'b0;
      end else if (access) begin
         prev_ok_q   <= 1'b1;
         prev_addr_q <= addr;
         prev_rd_q   <= rd;
         cnt_q       <= (idx == last_idx) ? '0 : idx + 1'b1;
      end
   end

   AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr && rd)); // R3
   AST_IDX_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      access |-> (idx <= last_idx)); // R2
   AST_IDX_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      (access && idx == last_idx) ##1 (access && addr == $past(addr) && rd == $past(rd))
      |-> (idx == '0)); // R2
endmodule

// File: rtl/adcemu_byte_asm.sv
module adcemu_byte_asm
   import adcemu_pkg::*;
#(
   parameter int W = 96
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [IDX_W-1:0] idx,
   input  logic [7:0]       wdata,
   output logic [W-1:0]     word,
   output logic             last
);
   localparam int NB = bytes_per_word(W);

   generate
      if (W % HOST_W != 0) begin : g_bad_w
         $error("word width must be a whole number of bytes");
      end
   endgenerate

   logic [W-1:0] asm_q;
   logic [W-1:0] asm_nx;

   always_comb begin
      asm_nx = asm_q;
      asm_nx[int'(idx)*HOST_W +: HOST_W] = wdata;
   end

   assign word = asm_nx;
   assign last = (idx == IDX_W'(NB - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         asm_q <= '0;
      end else if (wr) begin
         asm_q <= asm_nx;
      end
   end
endmodule

// File: rtl/adcemu_replay_buf.sv
module adcemu_replay_buf
   import adcemu_pkg::*;
#(
   parameter int W     = 96,
   parameter int DEPTH = 512
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             samp_mode,
   input  logic             samp_en,
   input  logic [IDX_W-1:0] idx,
   input  logic             host_wr,
   input  logic             host_rd,
   input  logic [7:0]       host_wdata,
   output logic [7:0]       host_rbyte,
   output logic [W-1:0]     dout,
   output logic             dout_valid,
   output logic             full,
   output logic             empty
);
   localparam int AW = $clog2(DEPTH);

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("replay depth must be a power of two");
      end
   endgenerate

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wr_ptr_q, rd_ptr_q;
   logic [AW:0]   count_q;
   logic [W-1:0]  new_word;
   logic [W-1:0]  rd_word;
   logic          last;
   logic          wr_ok, rd_ok, step;

   adcemu_byte_asm #(.W(W)) asm_i (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (host_wr),
      .idx   (idx),
      .wdata (host_wdata),
      .word  (new_word),
      .last  (last)
   );

   assign full  = (count_q == (AW+1)'(DEPTH));
   assign empty = (count_q == '0);
   assign wr_ok = host_wr && last && !full;
   assign rd_ok = host_rd && last && !empty && !samp_mode;
   assign step  = rd_ok || (samp_mode && samp_en);

   assign rd_word    = mem[rd_ptr_q];
   assign host_rbyte = (empty || samp_mode) ? 8'h00 : rd_word[int'(idx)*HOST_W +: HOST_W];

   always_ff @(posedge clk) begin
      if (wr_ok) begin
         mem[wr_ptr_q] <= new_word;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr_q   <= '0;
         rd_ptr_q   <= '0;
         count_q    <= '0;
         dout       <= '0;
         dout_valid <= 1'b0;
      end else begin
         if (wr_ok) wr_ptr_q <= wr_ptr_q + 1'b1;
         if (step)  rd_ptr_q <= rd_ptr_q + 1'b1;
         case ({wr_ok, rd_ok})
            2'b10:   count_q <= count_q + 1'b1;
            2'b01:   count_q <= count_q - 1'b1;
            default: count_q <= count_q;
         endcase
         if (samp_mode && samp_en) begin
            dout       <= rd_word;
            dout_valid <= 1'b1;
         end else begin
            dout_valid <= 1'b0;
         end
      end
   end

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      count_q <= (AW+1)'(DEPTH)); // R8
   AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(full && empty)); // R7
   AST_REPLAY_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (samp_mode && samp_en && rd_ptr_q == AW'(DEPTH - 1)) |=> (rd_ptr_q == '0)); // R5
   AST_REPLAY_KEEPS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      (samp_mode && !host_wr) |=> $stable(count_q)); // R5
   AST_VALID_FROM_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      dout_valid |-> $past(samp_en && samp_mode)); // R5
   AST_BLOCKED_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rd && (samp_mode || empty)) |-> (host_rbyte == 8'h00)); // R9
endmodule

// File: rtl/adcemu_capture_buf.sv
module adcemu_capture_buf
   import adcemu_pkg::*;
#(
   parameter int W     = 96,
   parameter int DEPTH = 512
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             samp_mode,
   input  logic             samp_en,
   input  logic [W-1:0]     samp_din,
   input  logic [IDX_W-1:0] idx,
   input  logic             host_wr,
   input  logic             host_rd,
   input  logic [7:0]       host_wdata,
   output logic [7:0]       host_rbyte,
   output logic             full,
   output logic             empty
);
   localparam int AW = $clog2(DEPTH);

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("capture depth must be a power of two");
      end
   endgenerate

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wr_ptr_q, rd_ptr_q;
   logic [AW:0]   count_q;
   logic [W-1:0]  host_word;
   logic [W-1:0]  store_word;
   logic [W-1:0]  rd_word;
   logic          last;
   logic          host_ok, samp_ok, wr_ok, rd_ok;

   adcemu_byte_asm #(.W(W)) asm_i (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (host_wr),
      .idx   (idx),
      .wdata (host_wdata),
      .word  (host_word),
      .last  (last)
   );

   assign full       = (count_q == (AW+1)'(DEPTH));
   assign empty      = (count_q == '0);
   assign host_ok    = host_wr && last && !full && !samp_mode;
   assign samp_ok    = samp_mode && samp_en && !full;
   assign wr_ok      = host_ok || samp_ok;
   assign store_word = samp_mode ? samp_din : host_word;
   assign rd_ok      = host_rd && last && !empty;

   assign rd_word    = mem[rd_ptr_q];
   assign host_rbyte = empty ? 8'h00 : rd_word[int'(idx)*HOST_W +: HOST_W];

   always_ff @(posedge clk) begin
      if (wr_ok) begin
         mem[wr_ptr_q] <= store_word;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr_q <= '0;
         rd_ptr_q <= '0;
         count_q  <= '0;
      end else begin
         if (wr_ok) wr_ptr_q <= wr_ptr_q + 1'b1;
         if (rd_ok) rd_ptr_q <= rd_ptr_q + 1'b1;
         case ({wr_ok, rd_ok})
            2'b10:   count_q <= count_q + 1'b1;
            2'b01:   count_q <= count_q - 1'b1;
            default: count_q <= count_q;
         endcase
      end
   end

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      count_q <= (AW+1)'(DEPTH)); // R8
   AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(full && empty)); // R7
   AST_CAPTURE_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
      (full && samp_mode && !host_rd) |=> ($stable(wr_ptr_q) && full)); // R6
   AST_HOST_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (samp_mode && !samp_en && !host_rd) |=> $stable(count_q)); // R6
   AST_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rd && empty) |=> $stable(rd_ptr_q)); // R8
endmodule

// File: rtl/adcemu_top.sv
module adcemu_top
   import adcemu_pkg::*;
#(
   parameter int         STIM_W      = 96,
   parameter int         TRIG_W      = 8,
   parameter int         CAP_W       = 96,
   parameter int         DEPTH       = 512,
   parameter logic [7:0] STIM_ADDR   = ADDR_STIM,
   parameter logic [7:0] TRIG_ADDR   = ADDR_TRIG,
   parameter logic [7:0] CAP_ADDR    = ADDR_CAP,
   parameter logic [7:0] SETUP_ADDR  = ADDR_SETUP,
   parameter logic [7:0] STATUS_ADDR = ADDR_STATUS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [7:0]        host_addr,
   input  logic              host_wr,
   input  logic              host_rd,
   input  logic [7:0]        host_wdata,
   output logic [7:0]        host_rdata,
   input  logic              samp_en,
   output logic [STIM_W-1:0] stim_word,
   output logic              stim_valid,
   output logic [TRIG_W-1:0] trig_word,
   output logic              trig_valid,
   input  logic [CAP_W-1:0]  cap_din
);
   localparam int STIM_NB = bytes_per_word(STIM_W);
   localparam int TRIG_NB = bytes_per_word(TRIG_W);
   localparam int CAP_NB  = bytes_per_word(CAP_W);
   localparam int SETUP_W = 3;

   logic [IDX_W-1:0]   idx;
   logic [SETUP_W-1:0] setup_q;
   status_t            status;
   logic               sel_stim, sel_trig, sel_cap, sel_setup, sel_status;
   logic [7:0]         stim_rbyte, trig_rbyte, cap_rbyte;
   logic [7:0]         rd_mux;

   assign sel_stim   = (host_addr == STIM_ADDR);
   assign sel_trig   = (host_addr == TRIG_ADDR);
   assign sel_cap    = (host_addr == CAP_ADDR);
   assign sel_setup  = (host_addr == SETUP_ADDR);
   assign sel_status = (host_addr == STATUS_ADDR);

   adcemu_host_seq #(
      .STIM_NB   (STIM_NB),
      .TRIG_NB   (TRIG_NB),
      .CAP_NB    (CAP_NB),
      .STIM_ADDR (STIM_ADDR),
      .TRIG_ADDR (TRIG_ADDR),
      .CAP_ADDR  (CAP_ADDR)
   ) seq_i (
      .clk   (clk),
      .rst_n (rst_n),
      .addr  (host_addr),
      .wr    (host_wr),
      .rd    (host_rd),
      .idx   (idx)
   );

   adcemu_replay_buf #(.W(STIM_W), .DEPTH(DEPTH)) stim_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .samp_mode  (setup_q[SEL_STIM]),
      .samp_en    (samp_en),
      .idx        (idx),
      .host_wr    (host_wr && sel_stim),
      .host_rd    (host_rd && sel_stim),
      .host_wdata (host_wdata),
      .host_rbyte (stim_rbyte),
      .dout       (stim_word),
      .dout_valid (stim_valid),
      .full       (status.stim_full),
      .empty      (status.stim_empty)
   );

   adcemu_replay_buf #(.W(TRIG_W), .DEPTH(DEPTH)) trig_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .samp_mode  (setup_q[SEL_TRIG]),
      .samp_en    (samp_en),
      .idx        (idx),
      .host_wr    (host_wr && sel_trig),
      .host_rd    (host_rd && sel_trig),
      .host_wdata (host_wdata),
      .host_rbyte (trig_rbyte),
      .dout       (trig_word),
      .dout_valid (trig_valid),
      .full       (status.trig_full),
      .empty      (status.trig_empty)
   );

   adcemu_capture_buf #(.W(CAP_W), .DEPTH(DEPTH)) cap_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .samp_mode  (setup_q[SEL_CAP]),
      .samp_en    (samp_en),
      .samp_din   (cap_din),
      .idx        (idx),
      .host_wr    (host_wr && sel_cap),
      .host_rd    (host_rd && sel_cap),
      .host_wdata (host_wdata),
      .host_rbyte (cap_rbyte),
      .full       (status.cap_full),
      .empty      (status.cap_empty)
   );

   always_comb begin
      rd_mux = 8'h00;
      if (sel_stim)   rd_mux = stim_rbyte;
      if (sel_trig)   rd_mux = trig_rbyte;
      if (sel_cap)    rd_mux = cap_rbyte;
      if (sel_setup)  rd_mux = 8'(setup_q);
      if (sel_status) rd_mux = 8'(status);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         setup_q    <= '0;
         host_rdata <= 8'h00;
      end else begin
         if (host_wr && sel_setup) setup_q <= host_wdata[SETUP_W-1:0];
         if (host_rd)              host_rdata <= rd_mux;
      end
   end

   AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !host_rd |=> $stable(host_rdata)); // R10
   AST_SETUP_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rd && sel_setup && !$past(host_wr && sel_setup))
      |=> (host_rdata == 8'(setup_q))); // R4
endmodule

// File: tb/adcemu_tb_top.sv
module adcemu_top_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  host_addr = 8'h00;
   logic        host_wr = 1'b0;
   logic        host_rd = 1'b0;
   logic [7:0]  host_wdata = 8'h00;
   logic [7:0]  host_rdata;
   logic        samp_en = 1'b0;
   logic [95:0] stim_word;
   logic        stim_valid;
   logic [7:0]  trig_word;
   logic        trig_valid;
   logic [95:0] cap_din = '0;

   int tests = 0;
   int fails = 0;
   bit done  = 1'b0;

   localparam logic [7:0] A_STIM = 8'h1F, A_TRIG = 8'h06, A_CAP = 8'h1C;
   localparam logic [7:0] A_SETUP = 8'h10, A_STAT = 8'h11;
   localparam int DEPTH = 512;

   logic [95:0] stim_model [DEPTH];
   logic [95:0] cap_model  [DEPTH];
   logic [7:0]  trig_model [8];

   always #2 clk = ~clk;

   adcemu_top dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .host_addr  (host_addr),
      .host_wr    (host_wr),
      .host_rd    (host_rd),
      .host_wdata (host_wdata),
      .host_rdata (host_rdata),
      .samp_en    (samp_en),
      .stim_word  (stim_word),
      .stim_valid (stim_valid),
      .trig_word  (trig_word),
      .trig_valid (trig_valid),
      .cap_din    (cap_din)
   );

   function automatic logic [95:0] rnd96();
      return {$urandom(), $urandom(), $urandom()};
   endfunction

   // expected status value from the flag meanings of R7
   function automatic logic [7:0] stat_of(bit se, bit sf, bit te, bit tf, bit ce, bit cf);
      return {2'b00, cf, ce, tf, te, sf, se};
   endfunction

   task automatic chk(input string req, input logic [95:0] act, input logic [95:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // all tasks start and end on a falling edge
   task automatic hwrite(input logic [7:0] a, input logic [7:0] d);
      host_addr = a; host_wdata = d; host_wr = 1'b1;
      @(negedge clk);
      host_wr = 1'b0;
   endtask

   task automatic hread(input logic [7:0] a, output logic [7:0] d);
      host_addr = a; host_rd = 1'b1;
      @(negedge clk);
      host_rd = 1'b0;
      d = host_rdata;
   endtask

   task automatic put_word(input logic [7:0] a, input logic [95:0] w, input int nb);
      for (int i = 0; i < nb; i++) hwrite(a, w[i*8 +: 8]);
   endtask

   task automatic get_word(input logic [7:0] a, input int nb, output logic [95:0] w);
      logic [7:0] b;
      w = '0;
      for (int i = 0; i < nb; i++) begin
         hread(a, b);
         w[i*8 +: 8] = b;
      end
   endtask

   task automatic pulse_samp(input logic [95:0] din);
      cap_din = din; samp_en = 1'b1;
      @(negedge clk);
      samp_en = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      logic [7:0]  b;
      logic [95:0] w, wa, wb;
      int          seed;
      seed = $urandom(32'h5EED_1234);

      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      hread(A_STAT, b);  chk("R1 status", 96'(b), 96'(stat_of(1,0,1,0,1,0)));
      hread(A_SETUP, b); chk("R1 setup", 96'(b), 96'h0);
      chk("R1 stim_valid", 96'(stim_valid), 96'h0);
      chk("R1 trig_valid", 96'(trig_valid), 96'h0);

      // R2 R10 host round trip, stimulus and trigger
      for (int k = 0; k < 5; k++) begin
         stim_model[k] = rnd96();
         put_word(A_STIM, stim_model[k], 12);
      end
      hread(A_STAT, b); chk("R7 stim not empty", 96'(b), 96'(stat_of(0,0,1,0,1,0)));
      for (int k = 0; k < 5; k++) begin
         get_word(A_STIM, 12, w);
         chk("R2 stim readback", w, stim_model[k]);
      end
      for (int k = 0; k < 3; k++) begin
         trig_model[k] = 8'($urandom());
         hwrite(A_TRIG, trig_model[k]);
      end
      for (int k = 0; k < 3; k++) begin
         hread(A_TRIG, b);
         chk("R2 trig readback", 96'(b), 96'(trig_model[k]));
      end

      // R3 address change discards a partial word
      for (int i = 0; i < 5; i++) hwrite(A_STIM, 8'hEE);
      trig_model[0] = 8'h5A;
      hwrite(A_TRIG, trig_model[0]);
      hread(A_STAT, b); chk("R3 partial word not stored", 96'(b[0]), 96'h1);
      wa = rnd96();
      put_word(A_STIM, wa, 12);
      get_word(A_STIM, 12, w);
      chk("R3 word after address switch", w, wa);
      hread(A_TRIG, b); chk("R3 trig after switch", 96'(b), 96'h5A);

      // R3 direction change restarts; R8 empty read returns 0
      for (int i = 0; i < 6; i++) hwrite(A_STIM, 8'hC3);
      hread(A_STIM, b); chk("R8 empty stim read", 96'(b), 96'h0);
      wb = rnd96();
      put_word(A_STIM, wb, 12);
      get_word(A_STIM, 12, w);
      chk("R3 word after direction switch", w, wb);
      hread(A_CAP, b); chk("R8 empty capture read", 96'(b), 96'h0);

      // R7 R8 fill stimulus buffer, overflow dropped
      for (int k = 0; k < DEPTH; k++) begin
         stim_model[k] = rnd96();
         put_word(A_STIM, stim_model[k], 12);
      end
      hread(A_STAT, b); chk("R7 stim full", 96'(b), 96'(stat_of(0,1,1,0,1,0)));
      put_word(A_STIM, ~stim_model[0], 12);
      hread(A_STAT, b); chk("R8 still full after extra word", 96'(b), 96'(stat_of(0,1,1,0,1,0)));

      // R4 R9 sample mode for stimulus
      hwrite(A_SETUP, 8'h01);
      hread(A_SETUP, b); chk("R4 setup echo", 96'(b), 96'h1);
      hread(A_STIM, b);  chk("R9 host read blocked", 96'(b), 96'h0);

      // R5 replay with wrap past the last location
      for (int k = 0; k < DEPTH + 8; k++) begin
         pulse_samp('0);
         chk("R5 stim valid", 96'(stim_valid), 96'h1);
         chk("R5 stim replay word", stim_word, stim_model[k % DEPTH]);
         if (k == 0) chk("R4 trig idle in host mode", 96'(trig_valid), 96'h0);
      end
      @(negedge clk);
      chk("R5 valid single cycle", 96'(stim_valid), 96'h0);
      hread(A_STAT, b); chk("R5 count unchanged", 96'(b), 96'(stat_of(0,1,1,0,1,0)));

      // R5 trigger replay
      hwrite(A_SETUP, 8'h00);
      for (int k = 0; k < 4; k++) begin
         trig_model[k] = 8'($urandom());
         hwrite(A_TRIG, trig_model[k]);
      end
      hwrite(A_SETUP, 8'h02);
      for (int k = 0; k < 4; k++) begin
         pulse_samp('0);
         chk("R5 trig valid", 96'(trig_valid), 96'h1);
         chk("R5 trig replay word", 96'(trig_word), 96'(trig_model[k]));
      end
      hread(A_TRIG, b); chk("R9 trig read blocked", 96'(b), 96'h0);

      // R6 capture in sample mode, host writes ignored, stops at full
      hwrite(A_SETUP, 8'h04);
      for (int k = 0; k < 10; k++) begin
         cap_model[k] = rnd96();
         pulse_samp(cap_model[k]);
      end
      put_word(A_CAP, rnd96(), 12);
      for (int k = 10; k < DEPTH + 3; k++) begin
         w = rnd96();
         if (k < DEPTH) cap_model[k] = w;
         pulse_samp(w);
      end
      hread(A_STAT, b); chk("R6 capture full", 96'(b), 96'(stat_of(0,1,0,0,0,1)));
      for (int k = 0; k < DEPTH; k++) begin
         get_word(A_CAP, 12, w);
         chk("R6 capture readback", w, cap_model[k]);
      end
      hread(A_STAT, b); chk("R7 capture drained", 96'(b), 96'(stat_of(0,1,0,0,1,0)));
      hread(A_CAP, b);  chk("R6 no extra samples stored", 96'(b), 96'h0);

      // R2 random host-mode traffic on the capture buffer
      hwrite(A_SETUP, 8'h00);
      for (int r = 0; r < 20; r++) begin
         int n;
         n = 1 + int'($urandom() % 6);
         for (int k = 0; k < n; k++) begin
            cap_model[k] = rnd96();
            put_word(A_CAP, cap_model[k], 12);
         end
         for (int k = 0; k < n; k++) begin
            get_word(A_CAP, 12, w);
            chk("R2 random capture round trip", w, cap_model[k]);
         end
      end
      hread(A_STAT, b); chk("R10 final status", 96'(b), 96'(stat_of(0,1,0,0,1,0)));

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule